// File: doc/BRIEF.md
# Integer ALU With Condition Codes

This block is the arithmetic and logic stage of a 32-bit RISC integer pipe. It serves register-to-register and register-to-immediate instructions. The decoder hands it the six-bit operation field (instruction bits 24:19), the immediate-select bit (bit 13) and the 13-bit immediate (bits 12:0). The register file supplies the first source value and the second source value. The ALU forms the second operand, computes a 32-bit result in the same cycle, and reports any operation code it does not implement.

A four-bit condition register holds negative, zero, overflow and carry. The flag-setting forms of the arithmetic and logical operations write this register on the clock edge that ends an accepted cycle. The add-with-carry and subtract-with-borrow forms read the carry held in it. Shifts and the forms that do not set flags leave it alone.

Top module: `alu_flags`

## Requirements
- R1: While rst_n is low the four flags are 0, and they read 0 in the first cycle after reset is released.
- R2: With imm_sel = 1 the second operand is simm13 sign-extended from bit 12 to 32 bits. With imm_sel = 0 it is rs2_data.
- R3: The result is computed in the same cycle. op3 0x00 gives a+b, 0x04 gives a-b, 0x08 gives a+b+C and 0x0C gives a-b-C, where C is the held carry flag.
- R4: op3 0x01 gives a AND b, 0x02 gives a OR b and 0x03 gives a XOR b. 0x05 gives a AND NOT b, 0x06 gives a OR NOT b and 0x07 gives NOT(a XOR b).
- R5: op3 0x25 shifts a left and 0x26 shifts it right logically. 0x27 shifts it right arithmetically. In each case the count is bits 4:0 of the second operand.
- R6: Each of the ten codes in R3 and R4 plus 0x10 is a flag-setting form. It gives the same result, and when valid is high the flags are written at the next rising edge: N is result bit 31 and Z is 1 when the result is zero.
- R7: For the flag-setting arithmetic forms, V is two's-complement overflow. C is the carry out of bit 31 for add, and the borrow (unsigned a < b + carry-in) for subtract.
- R8: The flag-setting logical forms clear V and C.
- R9: The flags keep their value across an edge when valid is low, for the forms that do not set flags, and for the shifts.
- R10: Any other op3 drives result to 0 and illegal to 1 and leaves the flags unchanged. illegal is 0 for every listed code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| valid | input | 1 | The operation on the inputs is accepted this cycle |
| op3 | input | 6 | Operation code (instruction bits 24:19) |
| imm_sel | input | 1 | Selects the immediate as the second operand (instruction bit 13) |
| simm13 | input | 13 | Signed immediate (instruction bits 12:0) |
| rs1_data | input | 32 | First source operand |
| rs2_data | input | 32 | Second source register value |
| result | output | 32 | Combinational result |
| illegal | output | 1 | op3 is not implemented |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry / borrow flag |

## Verification
The assertions assume that every input is a known value while rst_n is high. They also assume that the inputs hold steady from one sampling edge to the next, so that a value seen with $past is the one that produced the flag update. The stimulus meets both conditions by driving every input at the falling edge from fully specified constants or $urandom values, with no X or Z. It mixes in codes outside the implemented set, so the illegal path and the hold of the flags are exercised under the same conditions.

// File: rtl/alu_flags.sv
module alu_flags (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid,
  input  logic [5:0]  op3,
  input  logic        imm_sel,
  input  logic [12:0] simm13,
  input  logic [31:0] rs1_data,
  input  logic [31:0] rs2_data,
  output logic [31:0] result,
  output logic        illegal,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_v,
  output logic        flag_c
);

  logic [31:0] a, b;
  logic [32:0] wide;
  logic        base_ok, is_shift, set_cc, v_next, c_next, cin;

  assign a        = rs1_data;
  assign b        = imm_sel ? {{19{simm13[12]}}, simm13} : rs2_data;
  assign is_shift = (op3 == 6'h25) || (op3 == 6'h26) || (op3 == 6'h27);
  assign base_ok  = !op3[5] && (!op3[3] || op3[2:0] == 3'd0 || op3[2:0] == 3'd4);
  assign illegal  = !(base_ok || is_shift);
  assign set_cc   = valid && base_ok && op3[4];
  assign cin      = op3[3] & flag_c;

  always_comb begin
    wide   = '0;
    result = '0;
    v_next = 1'b0;
    c_next = 1'b0;
    if (base_ok) begin
      case (op3[2:0])
        3'd0: begin
          wide   = {1'b0, a} + {1'b0, b} + {32'd0, cin};
          result = wide[31:0];
          v_next = (a[31] == b[31]) && (result[31] != a[31]);
          c_next = wide[32];
        end
        3'd4: begin
          wide   = {1'b0, a} - {1'b0, b} - {32'd0, cin};
          result = wide[31:0];
          v_next = (a[31] != b[31]) && (result[31] != a[31]);
          c_next = wide[32];
        end
        3'd1:    result = a & b;
        3'd2:    result = a | b;
        3'd3:    result = a ^ b;
        3'd5:    result = a & ~b;
        3'd6:    result = a | ~b;
        default: result = ~(a ^ b);
      endcase
    end else if (is_shift) begin
      case (op3[1:0])
        2'd1:    result = a << b[4:0];
        2'd2:    result = a >> b[4:0];
        default: result = 32'($signed(a) >>> b[4:0]);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
      flag_c <= 1'b0;
    end else if (set_cc) begin
      flag_n <= result[31];
      flag_z <= (result == 32'd0);
      flag_v <= v_next;
      flag_c <= c_next;
    end
  end

  assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (result == 32'd0));

  assert_illegal_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable({flag_n, flag_z, flag_v, flag_c}));

  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid || !op3[4] || op3[5]) |=> $stable({flag_n, flag_z, flag_v, flag_c}));

  assert_logic_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op3[5:3] == 3'b010 && op3[1:0] != 2'd0) |=> (!flag_v && !flag_c));

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_cc |=> (flag_z == ($past(result) == 32'd0)));

  assert_sub_borrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op3 == 6'h14) |=> (flag_c == ($past(a) < $past(b))));

endmodule

// File: tb/alu_flags_tb.sv
module alu_flags_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [5:0]  op3 = 6'h00;
  logic        imm_sel = 1'b0;
  logic [12:0] simm13 = 13'd0;
  logic [31:0] rs1_data = 32'd0;
  logic [31:0] rs2_data = 32'd0;
  logic [31:0] result;
  logic        illegal, flag_n, flag_z, flag_v, flag_c;

  int total = 0;
  int bad = 0;
  logic m_n = 1'b0, m_z = 1'b0, m_v = 1'b0, m_c = 1'b0;

  always #5 clk = ~clk;

  alu_flags u_dut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .op3(op3), .imm_sel(imm_sel),
    .simm13(simm13), .rs1_data(rs1_data), .rs2_data(rs2_data), .result(result),
    .illegal(illegal), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b, input logic c,
                       output logic [31:0] r, output logic ill, output logic cc,
                       output logic v, output logic co);
    logic [32:0] w;
    logic ci;
    r = 32'd0; ill = 1'b0; cc = 1'b0; v = 1'b0; co = 1'b0; w = '0;
    ci = (op[3:0] == 4'h8 || op[3:0] == 4'hC) ? c : 1'b0;
    if (op == 6'h25) r = a << b[4:0];
    else if (op == 6'h26) r = a >> b[4:0];
    else if (op == 6'h27) r = $unsigned($signed(a) >>> b[4:0]);
    else if (op[5] == 1'b0) begin
      cc = op[4];
      case (op[3:0])
        4'h0, 4'h8: begin
          w = {1'b0, a} + {1'b0, b} + {32'd0, ci}; r = w[31:0]; co = w[32];
          v = (a[31] == b[31]) && (r[31] != a[31]);
        end
        4'h4, 4'hC: begin
          w = {1'b0, a} - {1'b0, b} - {32'd0, ci}; r = w[31:0]; co = w[32];
          v = (a[31] != b[31]) && (r[31] != a[31]);
        end
        4'h1: r = a & b;
        4'h2: r = a | b;
        4'h3: r = a ^ b;
        4'h5: r = a & ~b;
        4'h6: r = a | ~b;
        4'h7: r = ~(a ^ b);
        default: begin ill = 1'b1; cc = 1'b0; end
      endcase
    end else ill = 1'b1;
  endtask

  function automatic string res_tag(input logic [5:0] op, input logic im);
    if (im) return "R2";
    if (op[5:3] == 3'b100 && op[2:0] >= 3'd5) return "R5";
    if (op[5] || (op[3] && op[2:0] != 3'd0 && op[2:0] != 3'd4)) return "R10";
    if (op[2:0] == 3'd0 || op[2:0] == 3'd4) return "R3";
    return "R4";
  endfunction

  task automatic step(input logic v, input logic [5:0] op, input logic im, input logic [12:0] s,
                      input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er, bo;
    logic eil, ecc, ev, ec;
    string ft;
    @(negedge clk);
    valid = v; op3 = op; imm_sel = im; simm13 = s; rs1_data = a; rs2_data = b;
    #1;
    bo = im ? {{19{s[12]}}, s} : b;
    model(op, a, bo, m_c, er, eil, ecc, ev, ec);
    check(result === er, res_tag(op, im), result, er);
    check(illegal === eil, "R10", {31'd0, illegal}, {31'd0, eil});
    ft = "R9";
    if (v && ecc) begin
      ft = (op[2:0] == 3'd0 || op[2:0] == 3'd4) ? "R7" : "R8";
      m_n = er[31]; m_z = (er == 32'd0); m_v = ev; m_c = ec;
    end
    @(posedge clk); #1;
    check({flag_n, flag_z, flag_v, flag_c} === {m_n, m_z, m_v, m_c}, ft,
          {28'd0, flag_n, flag_z, flag_v, flag_c}, {28'd0, m_n, m_z, m_v, m_c});
    if (v && ecc)
      check({flag_n, flag_z} === {er[31], er == 32'd0}, "R6",
            {30'd0, flag_n, flag_z}, {30'd0, er[31], er == 32'd0});
  endtask

  function automatic logic [5:0] pick(input int unsigned k);
    logic [5:0] codes [23] = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h08, 6'h0C,
                               6'h10, 6'h11, 6'h12, 6'h13, 6'h14, 6'h15, 6'h16, 6'h17, 6'h18, 6'h1C,
                               6'h25, 6'h26, 6'h27};
    return codes[k % 23];
  endfunction

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed_out;
    seed_out = $urandom(32'h5EED);
    repeat (3) @(posedge clk);
    #1;
    check({flag_n, flag_z, flag_v, flag_c} === 4'd0, "R1", {28'd0, flag_n, flag_z, flag_v, flag_c}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check({flag_n, flag_z, flag_v, flag_c} === 4'd0, "R1", {28'd0, flag_n, flag_z, flag_v, flag_c}, 32'd0);

    step(1, 6'h10, 0, 13'd0, 32'h7FFF_FFFF, 32'd1);
    step(1, 6'h10, 0, 13'd0, 32'hFFFF_FFFF, 32'd1);
    step(1, 6'h18, 0, 13'd0, 32'd5, 32'd6);
    step(1, 6'h14, 0, 13'd0, 32'd0, 32'd1);
    step(1, 6'h1C, 0, 13'd0, 32'd10, 32'd3);
    step(1, 6'h14, 0, 13'd0, 32'h8000_0000, 32'd1);
    step(1, 6'h00, 1, 13'h1FFF, 32'd100, 32'd0);
    step(1, 6'h10, 1, 13'h0FFF, 32'd1, 32'hDEAD_BEEF);
    step(1, 6'h15, 0, 13'd0, 32'hFFFF_0000, 32'h0F0F_0F0F);
    step(1, 6'h17, 0, 13'd0, 32'h1234_5678, 32'h1234_5678);
    step(1, 6'h27, 0, 13'd0, 32'h8000_0000, 32'h0000_003F);
    step(1, 6'h26, 1, 13'h1FE4, 32'h8000_0000, 32'd0);
    step(1, 6'h25, 0, 13'd0, 32'h0000_0001, 32'h0000_0020);
    step(1, 6'h3F, 0, 13'd0, 32'h1, 32'h1);
    step(1, 6'h19, 0, 13'd0, 32'h0, 32'h0);
    step(0, 6'h14, 0, 13'd0, 32'd0, 32'd1);
    step(1, 6'h04, 0, 13'd0, 32'd0, 32'd1);

    for (int i = 0; i < 400; i++) begin
      logic [5:0] op;
      op = ($urandom % 10 == 0) ? 6'($urandom) : pick($urandom);
      step(($urandom % 5) != 0, op, $urandom % 2 == 0, 13'($urandom), $urandom, $urandom);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule